// File: doc/BRIEF.md
# Per-Segment Page Table Walker

This block turns a virtual address into a physical address. Each address segment has its own small page table. The top bits of the virtual address pick a segment, and each segment has a base register and a bound register. The base holds the physical address where that segment's table starts. The bound holds how many entries the table has. Because of this, a table stores only the entries that its segment uses, and tables for different segments can have different lengths.

A translation request carries a 32-bit virtual address. The walker splits it into a segment number, a virtual page number (VPN) and a page offset. If the segment is not in use, or the VPN falls outside the table, the walker reports a fault and never touches memory. Otherwise it reads one page table entry through a request/response memory port, checks the entry's valid bit, and returns either the physical address or a page fault. Every result comes with a one-cycle done pulse. Software fills the base and bound registers through a write port.

Top module: `segPtWalker`

## Requirements
- R1: After reset, `reqReady` is 1 and both `doneValid` and `memReqValid` are 0.
- R2: The segment number is address bits 31:30 and the VPN is bits 29:12. The walker reads the entry at `base[segment] + VPN*4`, with the sum truncated to 32 bits.
- R3: A request with segment 3 finishes with `doneFault` = 1 (segment fault) and issues no memory read.
- R4: A VPN greater than or equal to the segment's bound finishes with `doneFault` = 2 (bound fault) and issues no memory read. A bound of 0 rejects every VPN, and VPN = bound-1 is still accepted.
- R5: A returned entry whose bit 31 is 0 gives `doneFault` = 3 (page fault).
- R6: A returned entry whose bit 31 is 1 gives `doneFault` = 0 and `donePa` = {entry bits 19:0, address bits 11:0}.
- R7: `doneValid` is high for exactly one cycle per request. `reqReady` is low from the cycle after a request is accepted until that request's done pulse has ended.
- R8: While `memReqValid` is high and `memReqReady` is low, both the request and `memReqAddr` stay unchanged.
- R9: A config write selects a segment with `cfgSel` and writes its bound (`cfgIsBound`=1, low 19 bits of `cfgData`) or its base (`cfgIsBound`=0). A write with `cfgSel` = 3 changes no register. A new bound takes effect for the next request.
- R10: On any fault, `donePa` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 2 | Segment whose register is written |
| cfgIsBound | input | 1 | 1 writes the bound, 0 writes the base |
| cfgData | input | 32 | Write data |
| reqValid | input | 1 | Translation request |
| reqVa | input | 32 | Virtual address to translate |
| reqReady | output | 1 | Walker idle and able to accept a request |
| memReqValid | output | 1 | Page table read request |
| memReqAddr | output | 32 | Physical address of the entry to read |
| memReqReady | input | 1 | Memory accepts the read |
| memRspValid | input | 1 | Read data is valid |
| memRspData | input | 32 | Returned page table entry |
| doneValid | output | 1 | One-cycle result strobe |
| donePa | output | 32 | Translated physical address |
| doneFault | output | 2 | 0 none, 1 segment, 2 bound, 3 page |

## Verification
The bench targets the bound edges: VPN equal to bound-1, VPN equal to bound, and a zero bound. An off-by-one comparison here would either reject the last valid entry or fetch a slot that does not exist. It also sends unused-segment requests and writes to the nonexistent fourth segment's registers. A design that decoded the segment poorly would issue a memory read, or would clobber a live segment's base. A memory port that stalls for two cycles out of three shows whether a request changes its address before it is taken. Entries with the valid bit clear catch a design that returns a stale frame instead of a page fault.

// File: rtl/segwalk_pkg.sv
package segwalk_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_SEG   = 2'd1,
    FLT_BOUND = 2'd2,
    FLT_PAGE  = 2'd3
  } fault_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   loadVa;
    logic   setFault;
    fault_e faultCode;
    logic   loadRsp;
  } walkCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic segBad;
    logic overBound;
  } walkStat_t;
endpackage

// File: rtl/segPtDatapath.sv
module segPtDatapath
  import segwalk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int SEG_W = 2,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20,
  parameter int PTE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [SEG_W-1:0]  cfgSel,
  input  logic              cfgIsBound,
  input  logic [VA_W-1:0]   cfgData,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [PTE_W-1:0]  memRspData,
  input  walkCtrl_t         ctrl,
  output walkStat_t         stat,
  output logic [VA_W-1:0]   pteAddr,
  output logic [PFN_W+OFF_W-1:0] paOut,
  output logic [1:0]        faultOut
);
  localparam int VPN_W   = VA_W - SEG_W - OFF_W;
  localparam int BND_W   = VPN_W + 1;
  localparam int SEG_CNT = (1 << SEG_W) - 1;
  localparam int PA_W    = PFN_W + OFF_W;

  logic [VA_W-1:0]  vaReg;
  logic [PA_W-1:0]  paReg;
  logic [1:0]       faultReg;
  logic [VA_W-1:0]  baseReg  [SEG_CNT];
  logic [BND_W-1:0] boundReg [SEG_CNT];

  genvar g;
  generate
    for (g = 0; g < SEG_CNT; g++) begin : gSeg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          baseReg[g]  <= '0;
          boundReg[g] <= '0;
        end else if (cfgWrEn && cfgSel == SEG_W'(g)) begin
          if (cfgIsBound) boundReg[g] <= cfgData[BND_W-1:0];
          else            baseReg[g]  <= cfgData;
        end
      end
    end
  endgenerate

  logic [SEG_W-1:0] segNum;
  logic [VPN_W-1:0] vpn;
  logic [VA_W-1:0]  selBase;
  logic [BND_W-1:0] selBound;

  assign segNum = vaReg[VA_W-1 -: SEG_W];
  assign vpn    = vaReg[OFF_W +: VPN_W];

  always_comb begin
    selBase  = '0;
    selBound = '0;
    for (int i = 0; i < SEG_CNT; i++) begin
      if (segNum == SEG_W'(i)) begin
        selBase  = baseReg[i];
        selBound = boundReg[i];
      end
    end
  end

  assign stat.segBad    = (32'(segNum) >= SEG_CNT);
  assign stat.overBound = ({1'b0, vpn} >= selBound);
  assign pteAddr        = selBase + (VA_W'(vpn) << 2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg    <= '0;
      paReg    <= '0;
      faultReg <= FLT_NONE;
    end else begin
      if (ctrl.loadVa) vaReg <= reqVa;
      if (ctrl.setFault) begin
        paReg    <= '0;
        faultReg <= ctrl.faultCode;
      end else if (ctrl.loadRsp) begin
        if (memRspData[PTE_W-1]) begin
          paReg    <= {memRspData[PFN_W-1:0], vaReg[OFF_W-1:0]};
          faultReg <= FLT_NONE;
        end else begin
          paReg    <= '0;
          faultReg <= FLT_PAGE;
        end
      end
    end
  end

  assign paOut    = paReg;
  assign faultOut = faultReg;
endmodule

// File: rtl/segPtControl.sv
module segPtControl
  import segwalk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  walkStat_t stat,
  output walkCtrl_t ctrl,
  output logic      reqReady,
  output logic      memReqValid,
  output logic      doneValid
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_REQ, S_WAIT, S_DONE} state_e;
  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState      = state;
    ctrl           = '0;
    ctrl.faultCode = FLT_NONE;
    unique case (state)
      S_IDLE: if (reqValid) begin
        ctrl.loadVa = 1'b1;
        nextState   = S_CHECK;
      end
      S_CHECK: begin
        if (stat.segBad) begin
          ctrl.setFault  = 1'b1;
          ctrl.faultCode = FLT_SEG;
          nextState      = S_DONE;
        end else if (stat.overBound) begin
          ctrl.setFault  = 1'b1;
          ctrl.faultCode = FLT_BOUND;
          nextState      = S_DONE;
        end else begin
          nextState = S_REQ;
        end
      end
      S_REQ:  if (memReqReady) nextState = S_WAIT;
      S_WAIT: if (memRspValid) begin
        ctrl.loadRsp = 1'b1;
        nextState    = S_DONE;
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_REQ);
  assign doneValid   = (state == S_DONE);
endmodule

// File: rtl/segPtWalker.sv
module segPtWalker
  import segwalk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int SEG_W = 2,
  parameter int OFF_W = 12,
  parameter int PFN_W = 20,
  parameter int PTE_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic [SEG_W-1:0]       cfgSel,
  input  logic                   cfgIsBound,
  input  logic [VA_W-1:0]        cfgData,
  input  logic                   reqValid,
  input  logic [VA_W-1:0]        reqVa,
  output logic                   reqReady,
  output logic                   memReqValid,
  output logic [VA_W-1:0]        memReqAddr,
  input  logic                   memReqReady,
  input  logic                   memRspValid,
  input  logic [PTE_W-1:0]       memRspData,
  output logic                   doneValid,
  output logic [PFN_W+OFF_W-1:0] donePa,
  output logic [1:0]             doneFault
);
  walkCtrl_t ctrl;
  walkStat_t stat;

  segPtControl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .stat(stat), .ctrl(ctrl), .reqReady(reqReady),
    .memReqValid(memReqValid), .doneValid(doneValid)
  );

  segPtDatapath #(
    .VA_W(VA_W), .SEG_W(SEG_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .PTE_W(PTE_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgIsBound(cfgIsBound), .cfgData(cfgData), .reqVa(reqVa),
    .memRspData(memRspData), .ctrl(ctrl), .stat(stat), .pteAddr(memReqAddr),
    .paOut(donePa), .faultOut(doneFault)
  );
endmodule

// File: rtl/segPtWalkerChk.sv
module segPtWalkerChk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            memReqValid,
  input logic            memReqReady,
  input logic [VA_W-1:0] memReqAddr,
  input logic            doneValid,
  input logic [PA_W-1:0] donePa,
  input logic [1:0]      doneFault
);
  logic readSeen;
  always_ff @(posedge clk) begin
    if (!rstN)                          readSeen <= 1'b0;
    else if (reqValid && reqReady)      readSeen <= 1'b0;
    else if (memReqValid && memReqReady) readSeen <= 1'b1;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R3
  seg_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneFault == 2'd1) |-> !readSeen);

  // R4
  bound_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneFault == 2'd2) |-> !readSeen);

  // R10
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneFault != 2'd0) |-> (donePa == '0));
endmodule

bind segPtWalker segPtWalkerChk #(.VA_W(VA_W), .PA_W(PFN_W + OFF_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqAddr(memReqAddr), .doneValid(doneValid), .donePa(donePa),
  .doneFault(doneFault)
);

// File: tb/segPtWalker_test.sv
module segPtWalker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic        cfgIsBound = 1'b0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0;
  logic        reqReady;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memReqReady = 1'b0;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        doneValid;
  logic [31:0] donePa;
  logic [1:0]  doneFault;

  always #(CLK_PERIOD/2) clk = ~clk;

  segPtWalker uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgIsBound(cfgIsBound), .cfgData(cfgData), .reqValid(reqValid),
    .reqVa(reqVa), .reqReady(reqReady), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .doneValid(doneValid), .donePa(donePa), .doneFault(doneFault)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bench model of the configured registers
  logic [31:0] mBase [3];
  logic [18:0] mBound [3];

  function automatic logic [31:0] pteFor(input logic [31:0] a);
    logic vbit;
    vbit = (a[3:2] != 2'b01);
    return {vbit, 11'd0, a[21:2] ^ 20'h5A5A5};
  endfunction

  // memory model with stalls and two-cycle latency
  logic [2:0]  readyPat = 3'b100;
  logic [1:0]  lat = '0;
  logic [31:0] lastAddr = '0;
  int          reads = 0;
  always @(posedge clk) begin
    readyPat    <= {readyPat[0], readyPat[2:1]};
    memReqReady <= readyPat[0];
    if (reqValid && reqReady) reads <= 0;
    if (memReqValid && memReqReady) begin
      lastAddr <= memReqAddr;
      reads    <= reads + 1;
      lat      <= 2'd2;
    end else if (lat != 0) begin
      lat <= lat - 1;
    end
    memRspValid <= (lat == 2'd1);
    memRspData  <= pteFor(lastAddr);
  end

  typedef struct {
    logic [31:0] pa;
    logic [1:0]  fault;
    int          nReads;
    logic [31:0] addr;
    string       req;
  } exp_t;
  exp_t expQ[$];

  task automatic cfgWrite(input logic [1:0] sel, input bit isBound,
                          input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgIsBound = isBound; cfgData = data;
    if (sel != 2'd3) begin
      if (isBound) mBound[sel] = data[18:0];
      else         mBase[sel]  = data;
    end
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic translate(input logic [31:0] va, input string req);
    exp_t e;
    logic [1:0]  seg;
    logic [17:0] vpn;
    seg = va[31:30];
    vpn = va[29:12];
    e.req = req;
    e.addr = '0;
    e.nReads = 0;
    e.pa = '0;
    if (seg == 2'd3) e.fault = 2'd1;
    else if ({1'b0, vpn} >= mBound[seg]) e.fault = 2'd2;
    else begin
      e.addr = mBase[seg] + {12'd0, vpn, 2'b00};
      e.nReads = 1;
      if (pteFor(e.addr)[31]) begin
        e.fault = 2'd0;
        e.pa = {pteFor(e.addr)[19:0], va[11:0]};
      end else e.fault = 2'd3;
    end
    expQ.push_back(e);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqVa = va;
    @(negedge clk);
    reqValid = 1'b0;
    while (!doneValid) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  bit prevDone = 0;
  bit holdPend = 0;
  logic [31:0] heldAddr = '0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (holdPend)
        check(memReqValid && memReqAddr == heldAddr, "R8", "held request",
              memReqAddr, heldAddr);
      holdPend = memReqValid && !memReqReady;
      heldAddr = memReqAddr;
      if (doneValid && prevDone)
        check(1'b0, "R7", "done wider than one cycle", 32'd1, 32'd0);
      if (doneValid && !prevDone) begin
        if (expQ.size() == 0) check(1'b0, "R7", "unexpected done", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = expQ.pop_front();
          check(doneFault == e.fault, e.req, "fault code", 32'(doneFault), 32'(e.fault));
          check(donePa == e.pa, e.req, "physical address", donePa, e.pa);
          check(reads == e.nReads, e.req, "read count", 32'(reads), 32'(e.nReads));
          if (e.nReads == 1)
            check(lastAddr == e.addr, "R2", "entry address", lastAddr, e.addr);
          check(!reqReady, "R7", "ready during done", 32'(reqReady), 32'd0);
        end
      end
      prevDone = doneValid;
    end
  end

  task automatic finish();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    for (int i = 0; i < 3; i++) begin mBase[i] = '0; mBound[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady", 32'(reqReady), 32'd1);
    check(doneValid == 1'b0, "R1", "doneValid", 32'(doneValid), 32'd0);
    check(memReqValid == 1'b0, "R1", "memReqValid", 32'(memReqValid), 32'd0);

    cfgWrite(2'd0, 1'b0, 32'h1000_0000);
    cfgWrite(2'd0, 1'b1, 32'd4);
    cfgWrite(2'd1, 1'b0, 32'h2000_0100);
    cfgWrite(2'd1, 1'b1, 32'h0004_0000);
    cfgWrite(2'd2, 1'b0, 32'h3000_0040);
    cfgWrite(2'd2, 1'b1, 32'd0);
    // R9 writes to segment 3 must not touch any live register
    cfgWrite(2'd3, 1'b0, 32'hDEAD_BEEF);
    cfgWrite(2'd3, 1'b1, 32'd0);

    translate(32'h0000_0ABC, "R6");            // seg0 vpn0 valid
    translate(32'h0000_3123, "R4");            // vpn3 = bound-1 accepted
    translate(32'h0000_4000, "R4");            // vpn4 = bound -> bound fault
    translate(32'h0000_1FFF, "R5");            // invalid entry
    translate(32'h7FFF_F555, "R2");            // seg1 largest vpn
    translate(32'h8000_0010, "R4");            // zero bound
    translate(32'hC000_1000, "R3");            // unused segment
    translate(32'hFFFF_FFFF, "R3");
    translate(32'h4000_0777, "R9");            // seg1 base after seg3 write
    cfgWrite(2'd2, 1'b1, 32'd8);
    translate(32'h8000_7321, "R9");            // new bound takes effect
    translate(32'h8000_8000, "R4");
    translate(32'h8000_5000, "R10");           // seg2 vpn5: entry bits 01 -> page fault

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R7", "results outstanding", 32'(expQ.size()), 32'd0);
    finish();
  end
endmodule